// File: doc/BRIEF.md
# ODT Power-Down Window Classifier

This block watches the termination-enable pin of a DDR3 device together with the sampled clock-enable. When the memory enters precharge power-down with its DLL frozen, the termination may follow the clock-synchronous rules or the asynchronous ones. The block tags every termination-enable edge as synchronous, transition or asynchronous. It then reports the earliest and latest time, in picoseconds after the edge's clock, at which the termination resistance may change. A controller can use these reports to schedule around the uncertainty, and a bus monitor can use them to check device behaviour.

The window opens WL-1 cycles before the first cycle in which the clock-enable is sampled low, so the classification must look back in time. Every edge therefore waits max(WL,1)-1 cycles in a short history before it is reported. If the clock-enable falls while an edge is still waiting, that edge is retagged. A refresh that is still running when the clock-enable falls keeps the window open until the refresh time has elapsed. Reports leave in order through a small queue with a valid/ready handshake.

Top module: `odtpd_window_tagger`

## Requirements
- R1: While reset is held, and until the first report is produced, `rpt_valid` is 0. The cycle stamp counts from 0 at the first clock edge after the internal reset is released.
- R2: Every change of `odt_pin` between two consecutive sampled cycles produces exactly one report. `rpt_stamp` holds the cycle index of the first sample at the new level, and `rpt_rise` holds that new level.
- R3: With `rpt_ready` high and the queue empty, a report for an edge sampled in cycle t becomes valid right after clock edge t+max(`wl`,1)-1. A `wl` of 0 behaves as 1. Reports leave in the order of their edges.
- R4: When `dll_run_pd` is 1, every report carries tag 0 (synchronous).
- R5: When `dll_run_pd` is 0 and the clock-enable is first sampled low in cycle c, edges in cycles c-(max(`wl`,1)-1) through c carry tag 1 (transition). Earlier edges carry tag 0.
- R6: After cycle c, while the clock-enable stays low, edges carry tag 2 (asynchronous) unless R7 applies.
- R7: A pulse on `ref_issue` in cycle r, with the clock-enable high, starts a refresh of `trfc_cyc` cycles. If r < c <= r+`trfc_cyc`, edges up to and including cycle r+`trfc_cyc` carry tag 1. A refresh that ended before cycle c has no effect.
- R8: A `ref_issue` pulse in a cycle where the clock-enable is sampled low is ignored, and it does not extend the window.
- R9: Edges in cycles where the clock-enable is sampled high again carry tag 0.
- R10: For a rising edge, the synchronous bounds are on_lat*tck+on_skew_min and on_lat*tck+on_skew_max. The asynchronous bounds are on_pd_min and on_pd_max. The transition bounds are the smaller of the two minimums and the larger of the two maximums.
- R11: For a falling edge, the bounds follow R10 with off_lat, off_skew_min/max and off_pd_min/max in place of the rising-edge values.
- R12: While `rpt_valid` is high and `rpt_ready` is low, every report field holds its value. The queue holds QDEPTH reports (4 by default). A report produced while the queue is full is discarded, and the reports already held are kept in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cke_q | input | 1 | Registered clock-enable as issued to the device |
| odt_pin | input | 1 | Termination-enable pin level |
| ref_issue | input | 1 | One-cycle pulse when a refresh command is issued |
| dll_run_pd | input | 1 | 1: DLL stays on in precharge power-down, so there is no window; 0: DLL frozen |
| wl | input | WL_W | Write latency in cycles |
| trfc_cyc | input | RFC_W | Refresh duration in cycles |
| tck_ps | input | PS_W | Clock period in ps |
| on_lat_cyc | input | LAT_W | Turn-on latency in cycles |
| off_lat_cyc | input | LAT_W | Turn-off latency in cycles |
| on_skew_min_ps | input | PS_W | Synchronous turn-on skew, minimum |
| on_skew_max_ps | input | PS_W | Synchronous turn-on skew, maximum |
| on_pd_min_ps | input | PS_W | Asynchronous turn-on delay, minimum |
| on_pd_max_ps | input | PS_W | Asynchronous turn-on delay, maximum |
| off_skew_min_ps | input | PS_W | Synchronous turn-off skew, minimum |
| off_skew_max_ps | input | PS_W | Synchronous turn-off skew, maximum |
| off_pd_min_ps | input | PS_W | Asynchronous turn-off delay, minimum |
| off_pd_max_ps | input | PS_W | Asynchronous turn-off delay, maximum |
| rpt_ready | input | 1 | Consumer accepts the head report |
| rpt_valid | output | 1 | A report is available |
| rpt_tag | output | 2 | 0 synchronous, 1 transition, 2 asynchronous |
| rpt_rise | output | 1 | 1 for a rising edge, 0 for a falling edge |
| rpt_stamp | output | STAMP_W | Cycle index of the edge |
| rpt_early_ps | output | PS_W | Earliest termination change |
| rpt_late_ps | output | PS_W | Latest termination change |

## Verification
The edge in cycle t is due at the output right after clock edge t+max(wl,1)-1. The bench drives each cycle's inputs on the falling clock and reads the outputs at the next falling edge, after the rising edge that sampled them. At the falling edge that follows sampling edge n, it expects a report exactly when an edge occurred in cycle n-(max(wl,1)-1), and it expects that cycle as the stamp. Keeping `rpt_ready` high drains one report per cycle, so no backlog can shift this timing. A separate stalled run holds `rpt_ready` low for several cycles. It checks that the head stays fixed, then releases the queue and counts the surviving entries one pop per cycle.

// File: rtl/odtpd_pkg.sv
package odtpd_pkg;
  typedef enum logic [1:0] {
    TAG_SYNC  = 2'd0,
    TAG_TRAN  = 2'd1,
    TAG_ASYNC = 2'd2
  } odt_tag_e;
endpackage

// File: rtl/odtpd_phase_track.sv
// Tracks clock-enable entry into power-down and the refresh still in flight;
// produces the tag that an edge sampled in the current cycle receives.
module odtpd_phase_track
  import odtpd_pkg::*;
#(
  parameter int RFC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_q,
  input  logic             ref_issue,
  input  logic             dll_run_pd,
  input  logic [RFC_W-1:0] trfc_cyc,
  output logic             fall_now,
  output odt_tag_e         cur_tag
);

  logic             cke_prev_q, cke_prev_d;
  logic [RFC_W-1:0] rfc_q, rfc_d;
  logic             rfc_en;
  logic             ref_take;

  always_comb begin
    fall_now   = cke_prev_q & ~cke_q;
    cke_prev_d = cke_q;
    // a refresh is only accepted while the clock-enable is high
    ref_take   = ref_issue & cke_q;
    rfc_en     = ref_take | (rfc_q != '0);
    rfc_d      = ref_take ? trfc_cyc : (rfc_q - RFC_W'(1));
    if (dll_run_pd || cke_q) begin
      cur_tag = TAG_SYNC;
    end else if (fall_now || (rfc_q != '0)) begin
      cur_tag = TAG_TRAN;
    end else begin
      cur_tag = TAG_ASYNC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_prev_q <= 1'b1;
      rfc_q      <= '0;
    end else begin
      cke_prev_q <= cke_prev_d;
      if (rfc_en) begin
        rfc_q <= rfc_d;
      end
    end
  end

  AST_FALL_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_now |=> !fall_now);  // R5

endmodule

// File: rtl/odtpd_edge_history.sv
// Detects termination-enable edges, delays each by max(wl,1)-1 cycles and
// retags synchronous entries as transition when the clock-enable falls.
module odtpd_edge_history
  import odtpd_pkg::*;
#(
  parameter int MAX_WL  = 16,
  parameter int STAMP_W = 16,
  parameter int WL_W    = $clog2(MAX_WL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               odt_pin,
  input  logic               fall_now,
  input  logic               dll_run_pd,
  input  odt_tag_e           cur_tag,
  input  logic [WL_W-1:0]    wl,
  output logic               ret_valid,
  output logic               ret_rise,
  output odt_tag_e           ret_tag,
  output logic [STAMP_W-1:0] ret_stamp
);

  localparam int DEPTH = (MAX_WL > 1) ? (MAX_WL - 1) : 1;

  logic               odt_prev_q;
  logic [STAMP_W-1:0] cyc_q, cyc_d;
  logic [WL_W-1:0]    wl_eff, ri;

  logic               ent_v [0:DEPTH];
  logic               ent_r [0:DEPTH];
  odt_tag_e           ent_t [0:DEPTH];
  logic [STAMP_W-1:0] ent_s [0:DEPTH];

  logic               hv_q [0:DEPTH-1];
  logic               hr_q [0:DEPTH-1];
  odt_tag_e           ht_q [0:DEPTH-1];
  logic [STAMP_W-1:0] hs_q [0:DEPTH-1];
  logic               hv_d [0:DEPTH-1];
  logic               hr_d [0:DEPTH-1];
  odt_tag_e           ht_d [0:DEPTH-1];
  logic [STAMP_W-1:0] hs_d [0:DEPTH-1];

  always_comb begin
    if (wl == '0) begin
      wl_eff = WL_W'(1);
    end else if (wl > WL_W'(MAX_WL)) begin
      wl_eff = WL_W'(MAX_WL);
    end else begin
      wl_eff = wl;
    end
    ri    = wl_eff - WL_W'(1);
    cyc_d = cyc_q + STAMP_W'(1);

    ent_v[0] = odt_pin ^ odt_prev_q;
    ent_r[0] = odt_pin;
    ent_t[0] = cur_tag;
    ent_s[0] = cyc_q;
    for (int k = 0; k < DEPTH; k++) begin
      ent_v[k+1] = hv_q[k];
      ent_r[k+1] = hr_q[k];
      ent_s[k+1] = hs_q[k];
      if (fall_now && !dll_run_pd && (ht_q[k] == TAG_SYNC)) begin
        ent_t[k+1] = TAG_TRAN;
      end else begin
        ent_t[k+1] = ht_q[k];
      end
    end

    for (int k = 0; k < DEPTH; k++) begin
      hv_d[k] = (WL_W'(k) < ri) ? ent_v[k] : 1'b0;
      hr_d[k] = ent_r[k];
      ht_d[k] = ent_t[k];
      hs_d[k] = ent_s[k];
    end

    ret_valid = ent_v[ri];
    ret_rise  = ent_r[ri];
    ret_tag   = ent_t[ri];
    ret_stamp = ent_s[ri];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odt_prev_q <= 1'b0;
      cyc_q      <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        hv_q[k] <= 1'b0;
        hr_q[k] <= 1'b0;
        ht_q[k] <= TAG_SYNC;
        hs_q[k] <= '0;
      end
    end else begin
      odt_prev_q <= odt_pin;
      cyc_q      <= cyc_d;
      for (int k = 0; k < DEPTH; k++) begin
        hv_q[k] <= hv_d[k];
        hr_q[k] <= hr_d[k];
        ht_q[k] <= ht_d[k];
        hs_q[k] <= hs_d[k];
      end
    end
  end

  AST_RETIRE_AGE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> ((cyc_q - ret_stamp) == STAMP_W'(ri)));  // R3
  AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && $past(ret_valid)) |-> (ret_stamp == ($past(ret_stamp) + STAMP_W'(1))));  // R3

endmodule

// File: rtl/odtpd_bound_calc.sv
// Combinational earliest/latest termination-change time for one edge.
module odtpd_bound_calc
  import odtpd_pkg::*;
#(
  parameter int PS_W  = 24,
  parameter int LAT_W = 5
) (
  input  logic             rise,
  input  odt_tag_e         tag,
  input  logic [PS_W-1:0]  tck_ps,
  input  logic [LAT_W-1:0] on_lat_cyc,
  input  logic [LAT_W-1:0] off_lat_cyc,
  input  logic [PS_W-1:0]  on_skew_min_ps,
  input  logic [PS_W-1:0]  on_skew_max_ps,
  input  logic [PS_W-1:0]  on_pd_min_ps,
  input  logic [PS_W-1:0]  on_pd_max_ps,
  input  logic [PS_W-1:0]  off_skew_min_ps,
  input  logic [PS_W-1:0]  off_skew_max_ps,
  input  logic [PS_W-1:0]  off_pd_min_ps,
  input  logic [PS_W-1:0]  off_pd_max_ps,
  output logic [PS_W-1:0]  early_ps,
  output logic [PS_W-1:0]  late_ps
);

  logic [LAT_W-1:0] lat;
  logic [PS_W-1:0]  base, sk_min, sk_max, pd_min, pd_max, sy_min, sy_max;

  always_comb begin
    lat    = rise ? on_lat_cyc      : off_lat_cyc;
    sk_min = rise ? on_skew_min_ps  : off_skew_min_ps;
    sk_max = rise ? on_skew_max_ps  : off_skew_max_ps;
    pd_min = rise ? on_pd_min_ps    : off_pd_min_ps;
    pd_max = rise ? on_pd_max_ps    : off_pd_max_ps;
    base   = {{(PS_W-LAT_W){1'b0}}, lat} * tck_ps;
    sy_min = base + sk_min;
    sy_max = base + sk_max;
    case (tag)
      TAG_SYNC: begin
        early_ps = sy_min;
        late_ps  = sy_max;
      end
      TAG_ASYNC: begin
        early_ps = pd_min;
        late_ps  = pd_max;
      end
      default: begin
        early_ps = (sy_min < pd_min) ? sy_min : pd_min;
        late_ps  = (sy_max > pd_max) ? sy_max : pd_max;
      end
    endcase
  end

endmodule

// File: rtl/odtpd_out_queue.sv
// Small in-order report queue; a push into a full queue is discarded.
module odtpd_out_queue #(
  parameter int DW     = 8,
  parameter int QDEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_valid,
  input  logic [DW-1:0] push_data,
  input  logic          pop_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  localparam int AW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [AW:0]   wr_q, wr_d, rd_q, rd_d;
  logic [DW-1:0] mem_q [0:QDEPTH-1];
  logic          full, do_push, do_pop;

  always_comb begin
    full      = (wr_q[AW] != rd_q[AW]) && (wr_q[AW-1:0] == rd_q[AW-1:0]);
    out_valid = (wr_q != rd_q);
    out_data  = mem_q[rd_q[AW-1:0]];
    do_push   = push_valid && !full;
    do_pop    = out_valid && pop_ready;
    wr_d      = wr_q + (AW+1)'(1);
    rd_d      = rd_q + (AW+1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (do_push) begin
        wr_q <= wr_d;
      end
      if (do_pop) begin
        rd_q <= rd_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem_q[wr_q[AW-1:0]] <= push_data;
    end
  end

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));  // R12

endmodule

// File: rtl/odtpd_window_tagger.sv
module odtpd_window_tagger
  import odtpd_pkg::*;
#(
  parameter int MAX_WL  = 16,
  parameter int RFC_W   = 10,
  parameter int PS_W    = 24,
  parameter int LAT_W   = 5,
  parameter int STAMP_W = 16,
  parameter int QDEPTH  = 4,
  parameter int WL_W    = $clog2(MAX_WL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke_q,
  input  logic               odt_pin,
  input  logic               ref_issue,
  input  logic               dll_run_pd,
  input  logic [WL_W-1:0]    wl,
  input  logic [RFC_W-1:0]   trfc_cyc,
  input  logic [PS_W-1:0]    tck_ps,
  input  logic [LAT_W-1:0]   on_lat_cyc,
  input  logic [LAT_W-1:0]   off_lat_cyc,
  input  logic [PS_W-1:0]    on_skew_min_ps,
  input  logic [PS_W-1:0]    on_skew_max_ps,
  input  logic [PS_W-1:0]    on_pd_min_ps,
  input  logic [PS_W-1:0]    on_pd_max_ps,
  input  logic [PS_W-1:0]    off_skew_min_ps,
  input  logic [PS_W-1:0]    off_skew_max_ps,
  input  logic [PS_W-1:0]    off_pd_min_ps,
  input  logic [PS_W-1:0]    off_pd_max_ps,
  input  logic               rpt_ready,
  output logic               rpt_valid,
  output logic [1:0]         rpt_tag,
  output logic               rpt_rise,
  output logic [STAMP_W-1:0] rpt_stamp,
  output logic [PS_W-1:0]    rpt_early_ps,
  output logic [PS_W-1:0]    rpt_late_ps
);

  localparam int DW = 2 + 1 + STAMP_W + 2 * PS_W;

  logic [1:0]         rst_pipe_q;
  logic               rst_int_n;
  logic               fall_now;
  odt_tag_e           cur_tag;
  logic               ret_valid, ret_rise;
  odt_tag_e           ret_tag;
  logic [STAMP_W-1:0] ret_stamp;
  logic [PS_W-1:0]    early_ps, late_ps;
  logic [DW-1:0]      push_data, head_data;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[1];

  odtpd_phase_track #(.RFC_W(RFC_W)) u_phase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cke_q      (cke_q),
    .ref_issue  (ref_issue),
    .dll_run_pd (dll_run_pd),
    .trfc_cyc   (trfc_cyc),
    .fall_now   (fall_now),
    .cur_tag    (cur_tag)
  );

  odtpd_edge_history #(.MAX_WL(MAX_WL), .STAMP_W(STAMP_W), .WL_W(WL_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .odt_pin    (odt_pin),
    .fall_now   (fall_now),
    .dll_run_pd (dll_run_pd),
    .cur_tag    (cur_tag),
    .wl         (wl),
    .ret_valid  (ret_valid),
    .ret_rise   (ret_rise),
    .ret_tag    (ret_tag),
    .ret_stamp  (ret_stamp)
  );

  odtpd_bound_calc #(.PS_W(PS_W), .LAT_W(LAT_W)) u_bound (
    .rise            (ret_rise),
    .tag             (ret_tag),
    .tck_ps          (tck_ps),
    .on_lat_cyc      (on_lat_cyc),
    .off_lat_cyc     (off_lat_cyc),
    .on_skew_min_ps  (on_skew_min_ps),
    .on_skew_max_ps  (on_skew_max_ps),
    .on_pd_min_ps    (on_pd_min_ps),
    .on_pd_max_ps    (on_pd_max_ps),
    .off_skew_min_ps (off_skew_min_ps),
    .off_skew_max_ps (off_skew_max_ps),
    .off_pd_min_ps   (off_pd_min_ps),
    .off_pd_max_ps   (off_pd_max_ps),
    .early_ps        (early_ps),
    .late_ps         (late_ps)
  );

  assign push_data = {ret_tag, ret_rise, ret_stamp, early_ps, late_ps};

  odtpd_out_queue #(.DW(DW), .QDEPTH(QDEPTH)) u_queue (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push_valid (ret_valid),
    .push_data  (push_data),
    .pop_ready  (rpt_ready),
    .out_valid  (rpt_valid),
    .out_data   (head_data)
  );

  assign {rpt_tag, rpt_rise, rpt_stamp, rpt_early_ps, rpt_late_ps} = head_data;

  AST_BOUND_ORDER: assert property (@(posedge clk) disable iff (!rst_int_n)
    rpt_valid |-> (rpt_early_ps <= rpt_late_ps));  // R10
  AST_ASYNC_NEEDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ret_valid && dll_run_pd && $stable(dll_run_pd)) |-> (ret_tag != TAG_ASYNC));  // R4

endmodule

// File: tb/odtpd_window_tagger_bench.sv
module odtpd_window_tagger_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_WL  = 16;
  localparam int RFC_W   = 10;
  localparam int PS_W    = 24;
  localparam int LAT_W   = 5;
  localparam int STAMP_W = 16;
  localparam int WL_W    = $clog2(MAX_WL + 1);

  localparam int TCK = 1250, ONL = 3, OFFL = 4;
  localparam int ONSK_MIN = 150, ONSK_MAX = 400, ONPD_MIN = 4000, ONPD_MAX = 8500;
  localparam int OFSK_MIN = 300, OFSK_MAX = 700, OFPD_MIN = 2000, OFPD_MAX = 5500;
  localparam int TRFC = 10, C_FALL = 20, C_RISE = 32, E_FIRST = 8, E_LAST = 39;

  logic clk, rst_n, cke_q, odt_pin, ref_issue, dll_run_pd, rpt_ready;
  logic [WL_W-1:0] wl;
  logic rpt_valid, rpt_rise;
  logic [1:0] rpt_tag;
  logic [STAMP_W-1:0] rpt_stamp;
  logic [PS_W-1:0] rpt_early_ps, rpt_late_ps;

  int checks = 0;
  int failures = 0;

  odtpd_window_tagger u_odtpd_window_tagger (
    .clk(clk), .rst_n(rst_n), .cke_q(cke_q), .odt_pin(odt_pin), .ref_issue(ref_issue),
    .dll_run_pd(dll_run_pd), .wl(wl), .trfc_cyc(RFC_W'(TRFC)), .tck_ps(PS_W'(TCK)),
    .on_lat_cyc(LAT_W'(ONL)), .off_lat_cyc(LAT_W'(OFFL)),
    .on_skew_min_ps(PS_W'(ONSK_MIN)), .on_skew_max_ps(PS_W'(ONSK_MAX)),
    .on_pd_min_ps(PS_W'(ONPD_MIN)), .on_pd_max_ps(PS_W'(ONPD_MAX)),
    .off_skew_min_ps(PS_W'(OFSK_MIN)), .off_skew_max_ps(PS_W'(OFSK_MAX)),
    .off_pd_min_ps(PS_W'(OFPD_MIN)), .off_pd_max_ps(PS_W'(OFPD_MAX)),
    .rpt_ready(rpt_ready), .rpt_valid(rpt_valid), .rpt_tag(rpt_tag), .rpt_rise(rpt_rise),
    .rpt_stamp(rpt_stamp), .rpt_early_ps(rpt_early_ps), .rpt_late_ps(rpt_late_ps)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  function automatic int ref_cycle(input int rc);
    case (rc)
      1: return 15;
      2: return 5;
      3: return 22;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_tag(input bit frozen, input int weff, input int rc, input int t);
    int ext_end, r;
    r = ref_cycle(rc);
    ext_end = C_FALL;
    if ((rc == 1 || rc == 2) && r < C_FALL && C_FALL <= r + TRFC) ext_end = r + TRFC;
    if (!frozen || t < C_FALL - (weff - 1) || t >= C_RISE) return 0;
    if (t <= ext_end) return 1;
    return 2;
  endfunction

  task automatic exp_bounds(input int tag, input bit rise, output int e, output int l);
    int smin, smax, pmin, pmax;
    smin = rise ? ONL * TCK + ONSK_MIN : OFFL * TCK + OFSK_MIN;
    smax = rise ? ONL * TCK + ONSK_MAX : OFFL * TCK + OFSK_MAX;
    pmin = rise ? ONPD_MIN : OFPD_MIN;
    pmax = rise ? ONPD_MAX : OFPD_MAX;
    if (tag == 0) begin e = smin; l = smax; end
    else if (tag == 2) begin e = pmin; l = pmax; end
    else begin e = (smin < pmin) ? smin : pmin; l = (smax > pmax) ? smax : pmax; end
  endtask

  task automatic do_reset(input bit run_pd, input int wlv, input bit chk);
    rst_n = 1'b0; odt_pin = 1'b0; cke_q = 1'b1; ref_issue = 1'b0; rpt_ready = 1'b1;
    dll_run_pd = run_pd; wl = WL_W'(wlv);
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (chk) check(rpt_valid === 1'b0, "R1", $sformatf("valid in reset act=%0b exp=0", rpt_valid));
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    if (chk) check(rpt_valid === 1'b0, "R1", $sformatf("valid after release act=%0b exp=0", rpt_valid));
  endtask

  task automatic run_sweep(input bit frozen, input int wlv, input int rc);
    int weff, seen, t, et, ee, el, r;
    string rq;
    bit ev;
    weff = (wlv == 0) ? 1 : wlv;
    r = ref_cycle(rc);
    seen = 0;
    do_reset(!frozen, wlv, (wlv == 0 && rc == 0));
    for (int n = 0; n < E_LAST + weff + 3; n++) begin
      cke_q = !(n >= C_FALL && n < C_RISE);
      ref_issue = (n == r);
      odt_pin = (n >= E_FIRST && n <= E_LAST) ? 1'((n - 7) % 2) : 1'b0;
      @(posedge clk);
      @(negedge clk);
      t = n - (weff - 1);
      ev = (t >= E_FIRST && t <= E_LAST);
      check(rpt_valid === ev, "R3",
            $sformatf("valid n=%0d wl=%0d act=%0b exp=%0b", n, wlv, rpt_valid, ev));
      if (rpt_valid === 1'b1 && ev) begin
        seen++;
        check(rpt_stamp == STAMP_W'(t) && rpt_rise == (t % 2 == 0), "R2",
              $sformatf("stamp/rise act=%0d/%0b exp=%0d/%0b", rpt_stamp, rpt_rise, t, (t % 2 == 0)));
        et = exp_tag(frozen, weff, rc, t);
        if (!frozen) rq = "R4";
        else if (t >= C_RISE) rq = "R9";
        else if (rc == 3 && t > C_FALL) rq = "R8";
        else if (rc == 1 && t > C_FALL && et == 1) rq = "R7";
        else if (t > C_FALL) rq = "R6";
        else rq = "R5";
        check(int'(rpt_tag) == et, rq,
              $sformatf("tag t=%0d wl=%0d rc=%0d act=%0d exp=%0d", t, wlv, rc, rpt_tag, et));
        exp_bounds(et, rpt_rise, ee, el);
        check(int'(rpt_early_ps) == ee && int'(rpt_late_ps) == el, rpt_rise ? "R10" : "R11",
              $sformatf("bounds tag=%0d act=%0d/%0d exp=%0d/%0d", et, rpt_early_ps, rpt_late_ps, ee, el));
      end
    end
    check(seen == E_LAST - E_FIRST + 1, "R2", $sformatf("count act=%0d exp=%0d", seen, E_LAST - E_FIRST + 1));
  endtask

  task automatic run_stall();
    do_reset(1'b1, 1, 1'b0);
    rpt_ready = 1'b0;
    for (int n = 0; n < 10; n++) begin
      odt_pin = (n < 6) ? 1'((n + 1) % 2) : 1'b0;
      @(posedge clk);
      @(negedge clk);
      if (n >= 3)
        check(rpt_valid === 1'b1 && rpt_stamp == 0 && rpt_rise == 1'b1, "R12",
              $sformatf("stalled head act=%0b/%0d exp=1/0", rpt_valid, rpt_stamp));
    end
    rpt_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      check(rpt_valid === 1'b1 && rpt_stamp == STAMP_W'(k), "R12",
            $sformatf("drain act=%0b/%0d exp=1/%0d", rpt_valid, rpt_stamp, k));
      @(posedge clk);
      @(negedge clk);
    end
    check(rpt_valid === 1'b0, "R12", $sformatf("dropped entries act valid=%0b exp=0", rpt_valid));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int f = 0; f < 2; f++)
      for (int w = 0; w <= 6; w++)
        for (int rc = 0; rc < 4; rc++)
          run_sweep(f[0], w, rc);
    run_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule